// File: doc/BRIEF.md
# Programmed I/O Cycle Engine with DMA Preemption

This block turns a single host register access into one programmed I/O read or write cycle on a parallel disk-interface bus. The cycle has four phases: address setup with the chip select asserted, a strobe-active phase, a recovery phase with the strobe released and the chip select still held, and then a single completion cycle. The length of each phase comes from a software-written cycle count. The engine captures all counts when it accepts the request, so the full range of programmed I/O speed grades is reached by choosing count values alone. The device can hold the strobe phase open with its ready line. A programmable limit ends an access that the device never releases and flags it as an error.

The host side is a plain request/ready port. The host raises `host_req` with the access fields and holds it until `host_ready` pulses. No data is buffered on the way through. A DMA sequencer may share the bus. For every access the engine raises `dma_pause`. If DMA is running, the engine waits until the sequencer reports `dma_paused`, which it does only between two DMA words. The engine then runs its cycle and drops `dma_pause` in the completion cycle, and the DMA burst continues.

The data pins are split into an input, an output and an output enable, ready for a tristate pad at chip level.

Top module: `pio_cycle_engine`

## Requirements
- R1: After reset, every chip select output is high (inactive), both strobes are high, `bus_doe` is 0, `host_ready` is 0 and `dma_pause` is 0.
- R2: The setup phase lasts exactly the programmed setup count in cycles. During it, the selected chip select is low, both strobes are high and `bus_addr` equals the accepted address.
- R3: With the device ready line high, the strobe phase lasts exactly the programmed strobe count. A read drives only `bus_rd_n` low and a write drives only `bus_wr_n` low.
- R4: The recovery phase lasts exactly the programmed recovery count with the chip select still low. In the first cycle after recovery, the chip select is high and `host_ready` is high for exactly one cycle.
- R5: A programmed count of 0 behaves as a count of 1 for every phase and for the ready-wait limit.
- R6: All counts are captured in the cycle the request is accepted. Changing the count inputs later has no effect on the cycle in progress.
- R7: If the ready line is low in the last programmed strobe cycle, the strobe stays low. It is released after the first cycle in which the ready line is sampled high.
- R8: If the ready line stays low in W consecutive cycles starting with the last programmed strobe cycle (W = the ready-wait limit), the strobe is released after the W-th such cycle and `host_err` is 1 with `host_ready`. Otherwise `host_err` is 0.
- R9: On a read, `host_rdata` equals the value `bus_din` held in the last cycle of the strobe phase.
- R10: On a write, `bus_doe` is high in every cycle from the first setup cycle through the last recovery cycle, and `bus_dout` equals the accepted write data. On a read, `bus_doe` stays 0.
- R11: `dma_pause` rises in the cycle after acceptance and falls in the `host_ready` cycle. While `dma_active` is high, the setup phase starts only after `dma_paused` is seen high, so no DMA word overlaps a bus cycle, and DMA words resume afterwards.
- R12: When `dma_active` is low at acceptance, the setup phase starts in the cycle right after acceptance.
- R13: `host_cs_sel` picks which chip select (bit index, active low) is driven. Only that one goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_setup_cnt | input | 8 | Address setup phase length in cycles |
| cfg_strobe_cnt | input | 8 | Minimum strobe-active phase length in cycles |
| cfg_recover_cnt | input | 8 | Recovery phase length in cycles |
| cfg_wait_limit | input | 8 | Maximum ready-wait cycles before the error exit |
| host_req | input | 1 | Access request, held until host_ready |
| host_write | input | 1 | 1 for a write access, 0 for a read |
| host_cs_sel | input | 1 | Index of the chip select to assert |
| host_addr | input | 3 | Register address on the bus |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Ready-wait limit hit, valid with host_ready |
| host_rdata | output | 16 | Captured read data |
| dma_active | input | 1 | DMA burst in progress |
| dma_paused | input | 1 | DMA sequencer stopped at a word boundary |
| dma_pause | output | 1 | Request to the DMA sequencer to hold off |
| bus_addr | output | 3 | Bus address |
| bus_cs_n | output | 2 | Chip selects, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_iordy | input | 1 | Device ready line |
| bus_dout | output | 16 | Data to the pad |
| bus_doe | output | 1 | Pad output enable |
| bus_din | input | 16 | Data from the pad |

## Verification
Reads and writes are run with short, long, zero and maximum counts, on both chip selects. These separate a phase that is off by one cycle, a zero count that wraps, and a swapped strobe or select. The device model changes `bus_din` on every strobe cycle, so only a capture in the final strobe cycle returns the expected word. The ready line is held low for fewer cycles than the strobe count, for long enough to stretch the strobe, and for longer than the wait limit, which separates no extension, extension and the error exit. A cycle whose count inputs change after acceptance, and cycles issued against a running DMA burst, show whether counts are captured at the right moment and whether any DMA word overlaps a bus cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAUSE,
        ST_SETUP,
        ST_ACTIVE,
        ST_RECOVER,
        ST_DONE
    } pio_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recover;
        logic [CNT_W-1:0] wait_lim;
    } pio_timing_t;

    // a programmed count of zero is read as one cycle
    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] raw_setup,
    input  logic [CNT_W-1:0] raw_active,
    input  logic [CNT_W-1:0] raw_recover,
    input  logic [CNT_W-1:0] raw_wait,
    output pio_timing_t      cur
);

    pio_timing_t held_d, held_q, fresh;

    always_comb begin
        fresh.setup    = clamp_count(raw_setup);
        fresh.active   = clamp_count(raw_active);
        fresh.recover  = clamp_count(raw_recover);
        fresh.wait_lim = clamp_count(raw_wait);
        held_d = load ? fresh : held_q;
        // the accepting cycle already sees the new values
        cur    = load ? fresh : held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '{setup: CNT_W'(1), active: CNT_W'(1),
                        recover: CNT_W'(1), wait_lim: CNT_W'(1)};
        end else begin
            held_q <= held_d;
        end
    end

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held_q)); // R6

endmodule

// File: rtl/pio_down_counter.sv
module pio_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec) begin
            cnt_d = cnt_q - W'(1);
        end
        zero = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_DEC_ABOVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0)); // R5

endmodule

// File: rtl/pio_dma_gate.sv
module pio_dma_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    input  logic dma_active,
    input  logic dma_paused,
    output logic dma_pause,
    output logic clear
);

    logic pause_d, pause_q;

    always_comb begin
        pause_d = pause_q;
        if (start) begin
            pause_d = 1'b1;
        end else if (finish) begin
            pause_d = 1'b0;
        end
        dma_pause = pause_q;
        clear     = !dma_active || dma_paused;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pause_q <= 1'b0;
        end else begin
            pause_q <= pause_d;
        end
    end

    AST_PAUSE_SET_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> dma_pause); // R11

endmodule

// File: rtl/pio_cycle_engine.sv
module pio_cycle_engine
    import pio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3,
    parameter int NUM_CS = 2,
    localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CNT_W-1:0]    cfg_setup_cnt,
    input  logic [CNT_W-1:0]    cfg_strobe_cnt,
    input  logic [CNT_W-1:0]    cfg_recover_cnt,
    input  logic [CNT_W-1:0]    cfg_wait_limit,
    input  logic                host_req,
    input  logic                host_write,
    input  logic [CS_IDX_W-1:0] host_cs_sel,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic                host_ready,
    output logic                host_err,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                dma_active,
    input  logic                dma_paused,
    output logic                dma_pause,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [NUM_CS-1:0]   bus_cs_n,
    output logic                bus_rd_n,
    output logic                bus_wr_n,
    input  logic                bus_iordy,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_doe,
    input  logic [DATA_W-1:0]   bus_din
);

    typedef struct packed {
        pio_state_e          st;
        logic                wr;
        logic [CS_IDX_W-1:0] cs;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
        logic                err;
    } eng_t;

    eng_t r_d, r_q;

    logic             accept, finish, gate_clear;
    logic             ph_load, ph_dec, ph_zero;
    logic             wt_load, wt_dec, wt_zero;
    logic [CNT_W-1:0] ph_val, wt_val;
    logic             in_bus;
    pio_timing_t      tm;

    pio_timing_regs u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .raw_setup   (cfg_setup_cnt),
        .raw_active  (cfg_strobe_cnt),
        .raw_recover (cfg_recover_cnt),
        .raw_wait    (cfg_wait_limit),
        .cur         (tm)
    );

    pio_down_counter #(.W(CNT_W)) u_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .dec      (ph_dec),
        .zero     (ph_zero)
    );

    pio_down_counter #(.W(CNT_W)) u_wait_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wt_load),
        .load_val (wt_val),
        .dec      (wt_dec),
        .zero     (wt_zero)
    );

    pio_dma_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .finish     (finish),
        .dma_active (dma_active),
        .dma_paused (dma_paused),
        .dma_pause  (dma_pause),
        .clear      (gate_clear)
    );

    always_comb begin
        r_d     = r_q;
        accept  = 1'b0;
        finish  = 1'b0;
        ph_load = 1'b0;
        ph_dec  = 1'b0;
        ph_val  = '0;
        wt_load = 1'b0;
        wt_dec  = 1'b0;
        wt_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_req) begin
                    accept    = 1'b1;
                    r_d.wr    = host_write;
                    r_d.cs    = host_cs_sel;
                    r_d.addr  = host_addr;
                    r_d.wdata = host_wdata;
                    r_d.err   = 1'b0;
                    if (dma_active) begin
                        r_d.st = ST_PAUSE;
                    end else begin
                        r_d.st  = ST_SETUP;
                        ph_load = 1'b1;
                        ph_val  = tm.setup - CNT_W'(1);
                    end
                end
            end
            ST_PAUSE: begin
                if (gate_clear) begin
                    r_d.st  = ST_SETUP;
                    ph_load = 1'b1;
                    ph_val  = tm.setup - CNT_W'(1);
                end
            end
            ST_SETUP: begin
                if (ph_zero) begin
                    r_d.st  = ST_ACTIVE;
                    ph_load = 1'b1;
                    ph_val  = tm.active - CNT_W'(1);
                    wt_load = 1'b1;
                    wt_val  = tm.wait_lim - CNT_W'(1);
                end else begin
                    ph_dec = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (!ph_zero) begin
                    ph_dec = 1'b1;
                end else if (bus_iordy || wt_zero) begin
                    r_d.rdata = bus_din;
                    r_d.err   = !bus_iordy;
                    r_d.st    = ST_RECOVER;
                    ph_load   = 1'b1;
                    ph_val    = tm.recover - CNT_W'(1);
                end else begin
                    wt_dec = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (ph_zero) begin
                    r_d.st = ST_DONE;
                    finish = 1'b1;
                end else begin
                    ph_dec = 1'b1;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_bus = (r_q.st == ST_SETUP) || (r_q.st == ST_ACTIVE) || (r_q.st == ST_RECOVER);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign bus_cs_n[g] = !(in_bus && (r_q.cs == CS_IDX_W'(g)));
    end

    assign bus_addr   = r_q.addr;
    assign bus_rd_n   = !((r_q.st == ST_ACTIVE) && !r_q.wr);
    assign bus_wr_n   = !((r_q.st == ST_ACTIVE) && r_q.wr);
    assign bus_doe    = in_bus && r_q.wr;
    assign bus_dout   = r_q.wdata;
    assign host_ready = (r_q.st == ST_DONE);
    assign host_err   = host_ready && r_q.err;
    assign host_rdata = r_q.rdata;

    AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_rd_n & bus_wr_n) |-> $past(!(&bus_cs_n))); // R2

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready); // R4

    AST_PAUSE_COVERS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(&bus_cs_n) |-> dma_pause); // R11

    AST_NO_DMA_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&bus_cs_n) && dma_active) |-> dma_paused); // R11

    AST_IORDY_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_ACTIVE) && ph_zero && !bus_iordy && !wt_zero) |=> !(bus_rd_n & bus_wr_n)); // R7

    AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> !(&bus_cs_n)); // R10

endmodule

// File: tb/pio_cycle_engine_tb_top.sv
module pio_cycle_engine_tb_top;

    localparam int DW  = 16;
    localparam int AW  = 3;
    localparam int NCS = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [7:0]    cfg_setup_cnt, cfg_strobe_cnt, cfg_recover_cnt, cfg_wait_limit;
    logic          host_req, host_write;
    logic [0:0]    host_cs_sel;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata;
    logic          host_ready, host_err;
    logic [DW-1:0] host_rdata;
    logic          dma_active, dma_paused, dma_pause;
    logic [AW-1:0] bus_addr;
    logic [NCS-1:0] bus_cs_n;
    logic          bus_rd_n, bus_wr_n, bus_iordy, bus_doe;
    logic [DW-1:0] bus_dout, bus_din;

    pio_cycle_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup_cnt(cfg_setup_cnt), .cfg_strobe_cnt(cfg_strobe_cnt),
        .cfg_recover_cnt(cfg_recover_cnt), .cfg_wait_limit(cfg_wait_limit),
        .host_req(host_req), .host_write(host_write), .host_cs_sel(host_cs_sel),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_err(host_err), .host_rdata(host_rdata),
        .dma_active(dma_active), .dma_paused(dma_paused), .dma_pause(dma_pause),
        .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_iordy(bus_iordy), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    int total = 0;
    int bad   = 0;

    typedef struct {
        bit wr;
        int cs;
        int addr;
        int wdata;
        int n_set;
        int n_act;
        int n_rec;
        bit err;
        int rdata;
    } exp_t;

    exp_t sb_q[$];

    int dev_low  = 0;
    int dev_base = 0;

    bit dma_run   = 1'b0;
    bit dma_word  = 1'b0;
    int dma_phase = 0;
    int dma_words = 0;
    int overlap   = 0;

    function automatic void chk(string req, string what, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endfunction

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    // DMA sequencer model: 3-cycle words, stops only at a word boundary
    always @(negedge clk) begin
        if (!dma_run) begin
            dma_active = 1'b0;
            dma_paused = 1'b0;
            dma_word   = 1'b0;
            dma_phase  = 0;
        end else begin
            dma_active = 1'b1;
            if (dma_paused && !dma_pause) dma_paused = 1'b0;
            if (!dma_paused) begin
                if (dma_phase == 0 && dma_pause) begin
                    dma_paused = 1'b1;
                    dma_word   = 1'b0;
                end else begin
                    dma_word = 1'b1;
                    if (dma_phase == 2) begin
                        dma_phase = 0;
                        dma_words++;
                    end else begin
                        dma_phase++;
                    end
                end
            end
            if (dma_word && (bus_cs_n != '1)) overlap++;
        end
    end

    // monitor + device model
    bit m_in = 1'b0;
    int m_set, m_act, m_rec, m_doe, m_cs, m_addr, m_rd, m_wr, m_dbad, m_cslow;

    always @(negedge clk) begin
        if (!rst_n) begin
            bus_iordy = 1'b1;
            bus_din   = '0;
        end else if (bus_cs_n != '1) begin
            if (!m_in) begin
                m_in = 1'b1;
                m_set = 0; m_act = 0; m_rec = 0; m_doe = 0;
                m_rd = 0; m_wr = 0; m_dbad = 0; m_cslow = 0;
                m_addr = int'(bus_addr);
            end
            m_cs = -1;
            for (int g = 0; g < NCS; g++) begin
                if (!bus_cs_n[g]) begin
                    m_cs = g;
                    m_cslow++;
                end
            end
            if (int'(bus_addr) != m_addr) m_dbad++;
            if (!bus_rd_n || !bus_wr_n) begin
                if (!bus_rd_n) m_rd++;
                if (!bus_wr_n) m_wr++;
                bus_iordy = !(m_act < dev_low);
                bus_din   = DW'(dev_base + m_act);
                m_act++;
            end else begin
                bus_iordy = 1'b1;
                if (m_act == 0) m_set++;
                else m_rec++;
            end
            if (bus_doe) begin
                m_doe++;
                if (sb_q.size() > 0 && int'(bus_dout) != sb_q[0].wdata) m_dbad++;
            end
        end else begin
            bus_iordy = 1'b1;
            if (m_in) begin
                exp_t e;
                m_in = 1'b0;
                if (sb_q.size() == 0) begin
                    chk("R3", "unexpected bus cycle", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk("R2", "setup cycles", m_set, e.n_set);
                    chk("R3", "strobe cycles", m_act, e.n_act);
                    chk("R3", "read strobe cycles", m_rd, e.wr ? 0 : e.n_act);
                    chk("R3", "write strobe cycles", m_wr, e.wr ? e.n_act : 0);
                    chk("R4", "recovery cycles", m_rec, e.n_rec);
                    chk("R4", "ready after recovery", int'(host_ready), 1);
                    chk("R13", "chip select index", m_cs, e.cs);
                    chk("R13", "selects low per cycle", m_cslow, e.n_set + e.n_act + e.n_rec);
                    chk("R2", "address", m_addr, e.addr);
                    chk("R10", "oe cycles", m_doe, e.wr ? (e.n_set + e.n_act + e.n_rec) : 0);
                    chk("R10", "data/address mismatches", m_dbad, 0);
                    chk("R11", "pause low at ready", int'(dma_pause), 0);
                end
            end
        end
    end

    task automatic run_cycle(bit wr, int cs, int addr, int wdata,
                             int t1, int t2, int t4, int w, int low,
                             bit perturb, string tag);
        exp_t e;
        int stalls;
        bit seen;
        e.wr = wr; e.cs = cs; e.addr = addr; e.wdata = wdata;
        e.n_set = eff(t1);
        e.n_rec = eff(t4);
        stalls = low - eff(t2) + 1;
        if (stalls < 0) stalls = 0;
        e.err   = (stalls >= eff(w));
        e.n_act = e.err ? (eff(t2) - 1 + eff(w)) : (eff(t2) + stalls);
        dev_low  = low;
        dev_base = 'h1200 + 16 * sb_q.size() + t2;
        e.rdata  = (dev_base + e.n_act - 1) & 'hFFFF;
        sb_q.push_back(e);

        @(negedge clk);
        cfg_setup_cnt   = 8'(t1);
        cfg_strobe_cnt  = 8'(t2);
        cfg_recover_cnt = 8'(t4);
        cfg_wait_limit  = 8'(w);
        host_write  = wr;
        host_cs_sel = 1'(cs);
        host_addr   = AW'(addr);
        host_wdata  = DW'(wdata);
        host_req    = 1'b1;
        @(negedge clk);
        chk("R11", {tag, " pause after accept"}, int'(dma_pause), 1);
        if (dma_run) chk("R11", {tag, " bus idle until paused"}, int'(bus_cs_n != '1), 0);
        else         chk("R12", {tag, " setup right after accept"}, int'(bus_cs_n != '1), 1);
        if (perturb) begin
            cfg_setup_cnt   = 8'(t1 + 5);
            cfg_strobe_cnt  = 8'(t2 + 5);
            cfg_recover_cnt = 8'(t4 + 5);
            cfg_wait_limit  = 8'(w + 5);
        end
        seen = 1'b0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            if (host_ready) seen = 1'b1;
            else @(negedge clk);
        end
        chk("R4", {tag, " ready seen"}, int'(seen), 1);
        chk("R8", {tag, " error flag"}, int'(host_err), int'(e.err));
        if (!wr && !e.err) chk("R9", {tag, " read data"}, int'(host_rdata), e.rdata);
        host_req = 1'b0;
        @(negedge clk);
        chk("R4", {tag, " ready single cycle"}, int'(host_ready), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w0;
        rst_n = 1'b0;
        host_req = 1'b0; host_write = 1'b0; host_cs_sel = '0;
        host_addr = '0; host_wdata = '0;
        cfg_setup_cnt = 8'd1; cfg_strobe_cnt = 8'd1;
        cfg_recover_cnt = 8'd1; cfg_wait_limit = 8'd1;
        repeat (3) @(negedge clk);
        chk("R1", "cs during reset", int'(bus_cs_n), 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cs idle", int'(bus_cs_n), 3);
        chk("R1", "strobes idle", int'({bus_rd_n, bus_wr_n}), 3);
        chk("R1", "oe idle", int'(bus_doe), 0);
        chk("R1", "ready idle", int'(host_ready), 0);
        chk("R1", "pause idle", int'(dma_pause), 0);

        run_cycle(1, 0, 5, 'hA55A, 2, 3, 2, 4, 0, 0, "R2 R3 R10 write");
        run_cycle(0, 1, 2, 0, 1, 4, 3, 4, 0, 0, "R9 R13 read cs1");
        run_cycle(0, 0, 7, 0, 0, 0, 0, 0, 0, 0, "R5 zero counts");
        run_cycle(1, 1, 3, 'h1234, 7, 10, 5, 2, 0, 0, "slow write");
        run_cycle(1, 0, 1, 'hBEEF, 1, 255, 1, 1, 0, 0, "max strobe");
        run_cycle(0, 0, 4, 0, 2, 5, 2, 8, 2, 0, "R7 short not ready");
        run_cycle(0, 1, 6, 0, 1, 3, 1, 10, 6, 0, "R7 extend");
        run_cycle(0, 0, 0, 0, 1, 2, 1, 5, 50, 0, "R8 timeout");
        run_cycle(1, 0, 2, 'h0F0F, 3, 4, 2, 0, 40, 0, "R8 timeout limit zero");
        run_cycle(1, 1, 5, 'h7777, 3, 2, 4, 3, 0, 1, "R6 perturb");

        dma_run = 1'b1;
        repeat (7) @(negedge clk);
        run_cycle(0, 1, 3, 0, 2, 3, 2, 4, 0, 0, "R11 dma read");
        w0 = dma_words;
        repeat (12) @(negedge clk);
        chk("R11", "dma resumed", int'(dma_words > w0), 1);
        repeat (2) @(negedge clk);
        run_cycle(1, 0, 6, 'h4321, 1, 2, 1, 4, 0, 0, "R11 dma write");
        repeat (12) @(negedge clk);
        chk("R11", "no dma word overlap", overlap, 0);
        dma_run = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3", "scoreboard drained", sb_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule